// File: doc/BRIEF.md
# Common-Mode Offset Modulating Wave Generator

This block turns three signed phase reference samples into three modulating waves for a carrier-based three-phase PWM stage. Each time a sample strobe arrives, it finds the largest and the smallest of the three references. It then picks a distribution factor of zero, one half or one from a mode selector, computes a single common-mode offset from that factor and the extremes, and adds the offset to every phase. The results are saturated to the carrier range of plus or minus `RAIL`. They are registered and announced by a one-cycle valid strobe.

A single offset formula covers continuous space-vector modulation and several clamping schemes. With a factor of one, the largest wave is pinned to the positive rail. With a factor of zero, the smallest wave is pinned to the negative rail. Two sign-dependent modes choose between these two cases from the sign of (max + min). In clamping modes each phase rests on a rail for 120 electrical degrees per fundamental period. This removes roughly a third of the switching events. The sine references, carriers, comparators and dead time are handled elsewhere.

Top module: `cm_offset_modgen`

## Requirements
- R1: While reset (`rstN` low) is applied and after its release until the first strobe, `outValid` is 0 and all three modulating waves are 0.
- R2: `outValid` is high in exactly the clock cycle after each cycle in which `smpValid` was high, and low otherwise. One result is produced per strobe.
- R3: The same offset is added to all three references. An unsaturated pair of waves differs by exactly the difference of the corresponding references.
- R4: Mode code 0 (space vector) uses an offset of −floor((max+min)/2), where max and min are the largest and smallest of the three references.
- R5: Mode code 1 (low clamp) uses an offset of −RAIL − min, so the smallest wave equals −RAIL.
- R6: Mode code 2 (high clamp) uses an offset of RAIL − max, so the largest wave equals +RAIL.
- R7: Mode code 3 behaves as low clamp when max+min is negative and as high clamp when max+min is zero or positive.
- R8: Mode code 4 behaves as high clamp when max+min is negative and as low clamp when max+min is zero or positive.
- R9: Mode codes 5, 6 and 7 behave exactly as mode code 0.
- R10: Every modulating wave is limited to the range −RAIL to +RAIL. A value beyond that range is replaced by the nearer limit.
- R11: The mode and references are only taken at a strobe. Between strobes the outputs hold their last values, whatever the mode and reference inputs do.
- R12: The maximum and minimum are found from the current sample alone. A previous sample has no influence on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smpValid | input | 1 | Sample strobe, one cycle per sampling interval |
| mode | input | 3 | Algorithm selector, taken with the strobe |
| refA | input | DATA_W | Phase A reference, signed |
| refB | input | DATA_W | Phase B reference, signed |
| refC | input | DATA_W | Phase C reference, signed |
| outValid | output | 1 | Result strobe |
| modA | output | DATA_W | Phase A modulating wave, signed |
| modB | output | DATA_W | Phase B modulating wave, signed |
| modC | output | DATA_W | Phase C modulating wave, signed |

## Verification
The search for extremes, the offset and the saturation are all combinational behind one register. Every result is therefore due on the clock edge that follows the strobe edge, together with `outValid`. The driver applies inputs and the strobe on falling edges and queues the expected waves. The monitor pops one expected item on each falling edge where `outValid` is seen high, which is half a cycle after the result register loads, and compares all three phases. Hold behaviour is checked by moving the mode and reference inputs without a strobe over several cycles. The outputs must stay at the last popped values and `outValid` must stay low during that time.

// File: rtl/cmoff_pkg.sv
package cmoff_pkg;

  // Distribution factor applied to the extremes
  typedef enum logic [1:0] {
    FAC_ZERO = 2'd0,
    FAC_HALF = 2'd1,
    FAC_ONE  = 2'd2
  } factor_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    factor_e factor;
  } ctrl_s;

  localparam logic [2:0] MODE_SV         = 3'd0;
  localparam logic [2:0] MODE_LOCLAMP    = 3'd1;
  localparam logic [2:0] MODE_HICLAMP    = 3'd2;
  localparam logic [2:0] MODE_SIGNFOLLOW = 3'd3;
  localparam logic [2:0] MODE_SIGNINVERT = 3'd4;

endpackage

// File: rtl/cmoff_ctrl.sv
module cmoff_ctrl
  import cmoff_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       smpValid,
  input  logic [2:0] mode,
  input  logic       sumNeg,
  output ctrl_s      ctrlBus,
  output logic       outValid
);

  factor_e factorSel;

  // Factor chosen from the mode code; sign-dependent modes use sumNeg
  always_comb begin
    unique case (mode)
      MODE_LOCLAMP:    factorSel = FAC_ZERO;
      MODE_HICLAMP:    factorSel = FAC_ONE;
      MODE_SIGNFOLLOW: factorSel = sumNeg ? FAC_ZERO : FAC_ONE;
      MODE_SIGNINVERT: factorSel = sumNeg ? FAC_ONE  : FAC_ZERO;
      default:         factorSel = FAC_HALF;
    endcase
  end

  assign ctrlBus.load   = smpValid;
  assign ctrlBus.factor = factorSel;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= smpValid;
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    smpValid |=> outValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !smpValid |=> !outValid);

endmodule

// File: rtl/cmoff_dp.sv
module cmoff_dp
  import cmoff_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RAIL   = 12000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrl_s                         ctrlBus,
  input  logic signed [DATA_W-1:0]      refA,
  input  logic signed [DATA_W-1:0]      refB,
  input  logic signed [DATA_W-1:0]      refC,
  output logic                          sumNeg,
  output logic [2:0][DATA_W-1:0]        waveQ
);

  localparam int NPH   = 3;
  localparam int EXT_W = DATA_W + 3;
  typedef logic signed [EXT_W-1:0] ext_t;
  localparam ext_t RAIL_EXT = EXT_W'(RAIL);
  localparam logic signed [DATA_W-1:0] RAIL_W = DATA_W'(RAIL);

  logic signed [DATA_W-1:0] refArr [NPH];
  logic [NPH-1:0][DATA_W-1:0] satArr;
  ext_t vMax, vMin, sumMM, halfSum, offset;

  assign refArr[0] = refA;
  assign refArr[1] = refB;
  assign refArr[2] = refC;

  // Extremes, their sum and the common-mode offset
  always_comb begin
    vMax = ext_t'(refArr[0]);
    vMin = ext_t'(refArr[0]);
    for (int i = 1; i < NPH; i++) begin
      if (ext_t'(refArr[i]) > vMax) vMax = ext_t'(refArr[i]);
      if (ext_t'(refArr[i]) < vMin) vMin = ext_t'(refArr[i]);
    end
    sumMM   = vMax + vMin;
    halfSum = sumMM >>> 1;
    unique case (ctrlBus.factor)
      FAC_ZERO: offset = -RAIL_EXT - vMin;
      FAC_ONE:  offset = RAIL_EXT - vMax;
      default:  offset = -halfSum;
    endcase
  end

  assign sumNeg = sumMM[EXT_W-1];

  // Per-phase injection and saturation
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    ext_t rawV;
    always_comb begin
      rawV = ext_t'(refArr[p]) + offset;
      if (rawV > RAIL_EXT)       satArr[p] = RAIL_W;
      else if (rawV < -RAIL_EXT) satArr[p] = -RAIL_W;
      else                       satArr[p] = DATA_W'(rawV);
    end

    // R10
    wave_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($signed(waveQ[p]) <= RAIL_W) && ($signed(waveQ[p]) >= -RAIL_W));
  end

  always_ff @(posedge clk) begin
    if (!rstN)             waveQ <= '0;
    else if (ctrlBus.load) waveQ <= satArr;
  end

  // R11
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.load |=> $stable(waveQ));

  // R6
  hi_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.load && ctrlBus.factor == FAC_ONE) |=>
      ($signed(waveQ[0]) == RAIL_W || $signed(waveQ[1]) == RAIL_W ||
       $signed(waveQ[2]) == RAIL_W));

  // R5
  lo_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.load && ctrlBus.factor == FAC_ZERO) |=>
      ($signed(waveQ[0]) == -RAIL_W || $signed(waveQ[1]) == -RAIL_W ||
       $signed(waveQ[2]) == -RAIL_W));

endmodule

// File: rtl/cm_offset_modgen.sv
module cm_offset_modgen
  import cmoff_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RAIL   = 12000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     smpValid,
  input  logic [2:0]               mode,
  input  logic signed [DATA_W-1:0] refA,
  input  logic signed [DATA_W-1:0] refB,
  input  logic signed [DATA_W-1:0] refC,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] modA,
  output logic signed [DATA_W-1:0] modB,
  output logic signed [DATA_W-1:0] modC
);

  ctrl_s ctrlBus;
  logic  sumNeg;
  logic [2:0][DATA_W-1:0] waveQ;

  cmoff_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .smpValid (smpValid),
    .mode     (mode),
    .sumNeg   (sumNeg),
    .ctrlBus  (ctrlBus),
    .outValid (outValid)
  );

  cmoff_dp #(
    .DATA_W (DATA_W),
    .RAIL   (RAIL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlBus (ctrlBus),
    .refA    (refA),
    .refB    (refB),
    .refC    (refC),
    .sumNeg  (sumNeg),
    .waveQ   (waveQ)
  );

  assign modA = $signed(waveQ[0]);
  assign modB = $signed(waveQ[1]);
  assign modC = $signed(waveQ[2]);

endmodule

// File: tb/cm_offset_modgen_bench.sv
module cm_offset_modgen_bench;

  localparam int DW   = 16;
  localparam int RAIL = 12000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic smpValid = 1'b0;
  logic [2:0] mode = 3'd0;
  logic signed [DW-1:0] refA = '0, refB = '0, refC = '0;
  logic outValid;
  logic signed [DW-1:0] modA, modB, modC;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int    a;
    int    b;
    int    c;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t lastExp;

  always #4 clk = ~clk;

  cm_offset_modgen u_cm_offset_modgen (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .mode(mode),
    .refA(refA), .refB(refB), .refC(refC),
    .outValid(outValid), .modA(modA), .modB(modB), .modC(modC)
  );

  function automatic int satf(int v);
    if (v > RAIL) return RAIL;
    if (v < -RAIL) return -RAIL;
    return v;
  endfunction

  function automatic int floorHalf(int s);
    if (s >= 0) return s / 2;
    return -((-s + 1) / 2);
  endfunction

  // Expected waves from the requirements (R4..R10)
  function automatic exp_t model(int ra, int rb, int rc, int md, string tag);
    exp_t e;
    int mx, mn, s, off, fac;
    mx = ra; mn = ra;
    if (rb > mx) mx = rb;
    if (rc > mx) mx = rc;
    if (rb < mn) mn = rb;
    if (rc < mn) mn = rc;
    s = mx + mn;
    case (md)
      1: fac = 0;
      2: fac = 2;
      3: fac = (s < 0) ? 0 : 2;
      4: fac = (s < 0) ? 2 : 0;
      default: fac = 1;
    endcase
    if (fac == 0)      off = -RAIL - mn;
    else if (fac == 2) off = RAIL - mx;
    else               off = -floorHalf(s);
    e.a = satf(ra + off);
    e.b = satf(rb + off);
    e.c = satf(rc + off);
    e.tag = tag;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic sendSample(int ra, int rb, int rc, int md, string tag);
    sbq.push_back(model(ra, rb, rc, md, tag));
    @(negedge clk);
    refA = DW'(ra); refB = DW'(rb); refC = DW'(rc);
    mode = 3'(md);
    smpValid = 1'b1;
    @(negedge clk);
    smpValid = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each result as it appears
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R2", "outValid high with no pending sample (actual 1 expected 0)");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        lastExp = e;
        check(int'(modA) == e.a && int'(modB) == e.b && int'(modC) == e.c, e.tag,
              $sformatf("waves actual %0d %0d %0d expected %0d %0d %0d",
                        modA, modB, modC, e.a, e.b, e.c));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired (actual running expected finished)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    check(outValid == 1'b0 && modA == 0 && modB == 0 && modC == 0, "R1",
          $sformatf("in reset actual v=%0d %0d %0d %0d expected 0 0 0 0",
                    outValid, modA, modB, modC));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release, before any strobe
    check(outValid == 1'b0 && modA == 0 && modB == 0 && modC == 0, "R1",
          $sformatf("after release actual v=%0d %0d %0d %0d expected 0 0 0 0",
                    outValid, modA, modB, modC));

    // R4 space vector, even and odd sums
    sendSample(1000, -3000, 2000, 0, "R4");
    sendSample(3, -6, 0, 0, "R4");
    // R3 common offset, unsaturated
    sendSample(100, 200, -50, 0, "R3");
    // R5 and R6 fixed clamps
    sendSample(1000, -3000, 2000, 1, "R5");
    sendSample(1000, -3000, 2000, 2, "R6");
    // R7 sign-following: negative, positive, zero sum
    sendSample(1000, -3000, 2000, 3, "R7");
    sendSample(5000, -1000, 200, 3, "R7");
    sendSample(4000, -4000, 100, 3, "R7");
    // R8 sign-inverting: negative, positive, zero sum
    sendSample(1000, -3000, 2000, 4, "R8");
    sendSample(5000, -1000, 200, 4, "R8");
    sendSample(4000, -4000, 100, 4, "R8");
    // R9 spare codes act as space vector
    for (int m = 5; m < 8; m++) sendSample(1000, -3000, 2000, m, "R9");
    sendSample(-7, 4, 1, 6, "R9");
    // R10 saturation
    sendSample(12000, -14000, 0, 2, "R10");
    sendSample(30000, -10000, 0, 0, "R10");
    sendSample(-20000, 5000, 0, 1, "R10");
    // R12 fresh extremes after a wide sample
    sendSample(10, 20, 30, 2, "R12");
    sendSample(-30, -20, -10, 1, "R12");
    drain();

    // R2 no further strobe: outValid stays low
    check(outValid == 1'b0, "R2", $sformatf("idle actual %0d expected 0", outValid));

    // R11 inputs move without a strobe: outputs hold
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mode = 3'(k + 1);
      refA = DW'(500 * k - 900); refB = DW'(-300 * k); refC = DW'(700);
    end
    @(negedge clk);
    check(outValid == 1'b0 && int'(modA) == lastExp.a && int'(modB) == lastExp.b &&
          int'(modC) == lastExp.c, "R11",
          $sformatf("hold actual v=%0d %0d %0d %0d expected 0 %0d %0d %0d",
                    outValid, modA, modB, modC, lastExp.a, lastExp.b, lastExp.c));

    // R2 back-to-back strobes give one result each
    sbq.push_back(model(100, 0, -100, 0, "R2"));
    @(negedge clk);
    refA = DW'(100); refB = DW'(0); refC = DW'(-100); mode = 3'd0; smpValid = 1'b1;
    sbq.push_back(model(-500, 800, 0, 2, "R2"));
    @(negedge clk);
    refA = DW'(-500); refB = DW'(800); refC = DW'(0); mode = 3'd2;
    @(negedge clk);
    smpValid = 1'b0;
    drain();
    check(sbq.size() == 0 && outValid == 1'b0, "R2",
          $sformatf("pending actual %0d expected 0", sbq.size()));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule